// File: doc/BRIEF.md
# Banked Bit-Addressable Scratchpad

This block is the byte-wide working memory of a small controller core, reached through four ways of naming a location. A direct byte address covers the lower RAM and sends its upper half to an external special-register bus. An indirect byte address covers the lower RAM and, when the upper-RAM option is built, a second 128 bytes that only this mode can reach. A register number 0 to 7 is combined with a two-bit bank held inside the block. A bit address names one bit, either in a 16-byte window of RAM or in one of the special registers whose address is a multiple of eight.

Each access takes one cycle. The block works out the target byte and bit index. It then either reads or updates its own storage, or drives read and write strobes on the special-register port. Bit set, bit clear and bit write are done as a read-modify-write within that one cycle, so only the named bit changes. The pre-access content, or an error indication, is registered onto the result outputs at the end of the access cycle. The special registers themselves, the stack pointer and instruction decode live outside the block.

Top module: `scratchpad_ram`

## Requirements
- R1: In register mode (acc_mode 2) register n = acc_addr[2:0] is RAM byte {3'b000, bank, n}. A bank_ld pulse loads bank_sel at the end of its cycle, and an access in that same cycle still uses the old bank.
- R2: After reset the bank is 0, rd_data is 00h, rd_err is 0 and neither special-register strobe is active.
- R3: In direct mode (acc_mode 0) addresses 00h–7Fh reach RAM. Addresses 80h–FFh go to the special-register port with sfr_addr equal to the address and never touch RAM, even when upper RAM is built.
- R4: In indirect mode (acc_mode 1) addresses 00h–7Fh reach RAM. Addresses 80h–FFh reach upper RAM when UPPER_RAM is 1 and are invalid when it is 0.
- R5: In bit mode (acc_mode 3) a bit address b below 80h names bit b[2:0] of RAM byte 20h + b[6:3], with no special-register strobe.
- R6: A bit address b of 80h or above names bit b[2:0] of the special register at {b[7:3], 3'b000}. The access raises sfr_rd, and for a modifying op also raises sfr_wr in the same cycle, with sfr_wdata equal to sfr_rdata with that one bit updated.
- R7: Op codes are 0 read, 1 write, 2 set, 3 clear. In bit mode, set and clear force the bit and write copies acc_wdata[0] into it; no other bit of the byte changes. Byte writes and bit updates act on the same storage, so each view sees the other's changes.
- R8: On the clock edge ending an access, rd_data takes the pre-access content: the whole byte in byte modes, or the bit zero-extended in bit mode. A byte write to a special register returns 00h. With acc_en low, rd_data and rd_err hold.
- R9: An invalid access (set or clear outside bit mode, or an indirect address above 7Fh without upper RAM) sets rd_err, returns 00h, writes nothing and raises no strobe. A valid access clears rd_err.
- R10: The special-register strobes are active only during a valid access aimed at a special register. A byte write there drives sfr_wdata equal to acc_wdata, and a byte read returns sfr_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access in this cycle |
| acc_mode | input | 2 | 0 direct, 1 indirect, 2 register, 3 bit |
| acc_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| acc_addr | input | 8 | Byte address, register number (bits 2:0) or bit address |
| acc_wdata | input | 8 | Write byte; bit 0 is the value for a bit write |
| bank_ld | input | 1 | Load the bank select |
| bank_sel | input | 2 | New bank value |
| rd_data | output | 8 | Pre-access content of the last access |
| rd_err | output | 1 | Last access was invalid |
| sfr_rd | output | 1 | Special-register read strobe |
| sfr_wr | output | 1 | Special-register write strobe |
| sfr_addr | output | 8 | Special-register address |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, returned in the same cycle |

## Verification
The hardest case to reach from the ports is a bank change and a register access landing in the same cycle, where the access has to use the bank from before the load. The bench issues each bank load together with the first register write of the new bank. It then reads the whole bank area back through direct addresses, so a write that used the new bank too early lands in the wrong byte and shows up. Two copies, one with upper RAM and one without, receive identical stimulus. This exposes where indirect and direct handling of 80h–FFh differ between the configurations, and the bit sweeps cover every one of the 256 bit addresses with each op.

// File: rtl/scratchpad_pkg.sv
package scratchpad_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned BIT_IDX_W    = $clog2(BYTE_W);
  localparam int unsigned BANK_W       = 2;
  localparam logic [7:0]  BIT_WIN_BASE = 8'h20;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_REGISTER = 2'd2,
    AM_BIT      = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLR   = 2'd3
  } acc_op_e;

  typedef struct packed {
    logic                 valid;
    logic                 to_sfr;
    logic                 is_bit;
    logic [BYTE_W-1:0]    byte_addr;
    logic [BIT_IDX_W-1:0] bit_idx;
  } acc_target_t;

endpackage

// File: rtl/scratchpad_addr_map.sv
module scratchpad_addr_map
  import scratchpad_pkg::*;
#(
  parameter bit UPPER_RAM = 1'b0
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        op,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output acc_target_t       tgt
);

  localparam int unsigned REG_PAD_W = BYTE_W - BANK_W - 3;

  always_comb begin
    tgt         = '0;
    tgt.valid   = 1'b1;
    tgt.bit_idx = addr[BIT_IDX_W-1:0];
    case (acc_mode_e'(mode))
      AM_DIRECT: begin
        tgt.byte_addr = addr;
        tgt.to_sfr    = addr[BYTE_W-1];
      end
      AM_INDIRECT: begin
        tgt.byte_addr = addr;
        if (addr[BYTE_W-1] && !UPPER_RAM) begin
          tgt.valid = 1'b0;
        end
      end
      AM_REGISTER: begin
        tgt.byte_addr = {{REG_PAD_W{1'b0}}, bank, addr[2:0]};
      end
      default: begin
        tgt.is_bit = 1'b1;
        if (addr[BYTE_W-1]) begin
          tgt.to_sfr    = 1'b1;
          tgt.byte_addr = {addr[BYTE_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};
        end else begin
          tgt.byte_addr = BIT_WIN_BASE
                        | {{(BIT_IDX_W+1){1'b0}}, addr[BYTE_W-2:BIT_IDX_W]};
        end
      end
    endcase
    if (!tgt.is_bit && (acc_op_e'(op) == OP_SET || acc_op_e'(op) == OP_CLR)) begin
      tgt.valid = 1'b0;
    end
  end

endmodule

// File: rtl/scratchpad_bit_merge.sv
module scratchpad_bit_merge
  import scratchpad_pkg::*;
(
  input  logic [1:0]           op,
  input  logic                 is_bit,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic [BYTE_W-1:0]    old_byte,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    new_byte,
  output logic [BYTE_W-1:0]    old_view,
  output logic                 modifies
);

  always_comb begin
    new_byte = old_byte;
    case (acc_op_e'(op))
      OP_WRITE: begin
        if (is_bit) new_byte[bit_idx] = wdata[0];
        else        new_byte          = wdata;
      end
      OP_SET:  new_byte[bit_idx] = 1'b1;
      OP_CLR:  new_byte[bit_idx] = 1'b0;
      default: new_byte = old_byte;
    endcase
    modifies = (acc_op_e'(op) != OP_READ);
    old_view = is_bit ? {{(BYTE_W-1){1'b0}}, old_byte[bit_idx]} : old_byte;
  end

endmodule

// File: rtl/scratchpad_array.sv
module scratchpad_array
  import scratchpad_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata
);

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/scratchpad_ram.sv
module scratchpad_ram
  import scratchpad_pkg::*;
#(
  parameter bit UPPER_RAM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic [1:0] acc_mode,
  input  logic [1:0] acc_op,
  input  logic [7:0] acc_addr,
  input  logic [7:0] acc_wdata,
  input  logic       bank_ld,
  input  logic [1:0] bank_sel,
  output logic [7:0] rd_data,
  output logic       rd_err,
  output logic       sfr_rd,
  output logic       sfr_wr,
  output logic [7:0] sfr_addr,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);

  localparam int unsigned DEPTH   = UPPER_RAM ? 256 : 128;
  localparam int unsigned RAM_AW  = $clog2(DEPTH);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // bank select
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    if (bank_ld) bank_d = bank_sel;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bank_q <= '0;
    else            bank_q <= bank_d;
  end

  // address resolution
  acc_target_t tgt;

  scratchpad_addr_map #(.UPPER_RAM(UPPER_RAM)) i_addr_map (
    .mode (acc_mode),
    .op   (acc_op),
    .addr (acc_addr),
    .bank (bank_q),
    .tgt  (tgt)
  );

  // storage
  logic [BYTE_W-1:0] ram_rdata, old_byte, new_byte, old_view;
  logic              modifies, ram_we, acc_ok;

  assign acc_ok = acc_en && tgt.valid;
  assign ram_we = acc_ok && !tgt.to_sfr && modifies;

  scratchpad_array #(.DEPTH(DEPTH)) i_array (
    .clk   (clk),
    .we    (ram_we),
    .addr  (tgt.byte_addr[RAM_AW-1:0]),
    .wdata (new_byte),
    .rdata (ram_rdata)
  );

  assign old_byte = tgt.to_sfr ? sfr_rdata : ram_rdata;

  scratchpad_bit_merge i_merge (
    .op       (acc_op),
    .is_bit   (tgt.is_bit),
    .bit_idx  (tgt.bit_idx),
    .old_byte (old_byte),
    .wdata    (acc_wdata),
    .new_byte (new_byte),
    .old_view (old_view),
    .modifies (modifies)
  );

  // special-register port
  logic sfr_need_read;

  assign sfr_need_read = tgt.is_bit || (acc_op_e'(acc_op) == OP_READ);
  assign sfr_rd        = acc_ok && tgt.to_sfr && sfr_need_read;
  assign sfr_wr        = acc_ok && tgt.to_sfr && modifies;
  assign sfr_addr      = (sfr_rd || sfr_wr) ? tgt.byte_addr : '0;
  assign sfr_wdata     = sfr_wr ? new_byte : '0;

  // result registers
  logic [BYTE_W-1:0] rd_data_q, rd_data_d, result;
  logic              rd_err_q, rd_err_d;

  always_comb begin
    if (!tgt.valid)                    result = '0;
    else if (tgt.to_sfr && !sfr_rd)    result = '0;
    else                               result = old_view;
    rd_data_d = rd_data_q;
    rd_err_d  = rd_err_q;
    if (acc_en) begin
      rd_data_d = result;
      rd_err_d  = !tgt.valid;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_data_q <= '0;
      rd_err_q  <= 1'b0;
    end else begin
      rd_data_q <= rd_data_d;
      rd_err_q  <= rd_err_d;
    end
  end

  assign rd_data = rd_data_q;
  assign rd_err  = rd_err_q;

endmodule

// File: rtl/scratchpad_chk.sv
module scratchpad_chk #(
  parameter bit UPPER_RAM = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic [1:0] acc_mode,
  input logic [1:0] acc_op,
  input logic [7:0] acc_addr,
  input logic       sfr_rd,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic [7:0] rd_data,
  input logic       rd_err
);

  a_r9_err_returns_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == 8'h00);

  a_r10_strobe_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> acc_en);

  a_r3_direct_high_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'd0 && acc_addr[7] && acc_op == 2'd0)
      |-> (sfr_rd && !sfr_wr && sfr_addr == acc_addr));

  a_r6_bit_sfr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'd3 && (sfr_rd || sfr_wr))
      |-> (sfr_addr[2:0] == 3'b000 && sfr_addr[7:3] == acc_addr[7:3]));

  a_r7_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'd3 && sfr_wr)
      |-> ($countones(sfr_wdata ^ sfr_rdata) <= 1));

  a_r5_low_bit_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'd3 && !acc_addr[7]) |-> (!sfr_rd && !sfr_wr));

  a_r4_small_indirect_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!UPPER_RAM && acc_en && acc_mode == 2'd1 && acc_addr[7]) |=> rd_err);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> ($stable(rd_data) && $stable(rd_err)));

endmodule

bind scratchpad_ram scratchpad_chk #(.UPPER_RAM(UPPER_RAM)) i_scratchpad_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_mode  (acc_mode),
  .acc_op    (acc_op),
  .acc_addr  (acc_addr),
  .sfr_rd    (sfr_rd),
  .sfr_wr    (sfr_wr),
  .sfr_addr  (sfr_addr),
  .sfr_wdata (sfr_wdata),
  .sfr_rdata (sfr_rdata),
  .rd_data   (rd_data),
  .rd_err    (rd_err)
);

// File: tb/test_scratchpad_ram.sv
module test_scratchpad_ram;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en;
  logic [1:0] acc_mode, acc_op, bank_sel;
  logic [7:0] acc_addr, acc_wdata;
  logic       bank_ld;

  logic [7:0] rd_data_o   [2];
  logic       rd_err_o    [2];
  logic       sfr_rd_o    [2];
  logic       sfr_wr_o    [2];
  logic [7:0] sfr_addr_o  [2];
  logic [7:0] sfr_wdata_o [2];
  logic [7:0] sfr_rdata_o [2];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] mdl [2][256];
  logic [1:0] bank_m;

  always #5 clk = ~clk;

  // special registers modelled as a fixed pattern of their address
  assign sfr_rdata_o[0] = sfr_addr_o[0] ^ 8'hA5;
  assign sfr_rdata_o[1] = sfr_addr_o[1] ^ 8'hA5;

  scratchpad_ram #(.UPPER_RAM(1'b0)) i_scratchpad_ram (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode), .acc_op(acc_op),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .bank_ld(bank_ld), .bank_sel(bank_sel),
    .rd_data(rd_data_o[0]), .rd_err(rd_err_o[0]), .sfr_rd(sfr_rd_o[0]), .sfr_wr(sfr_wr_o[0]),
    .sfr_addr(sfr_addr_o[0]), .sfr_wdata(sfr_wdata_o[0]), .sfr_rdata(sfr_rdata_o[0])
  );

  scratchpad_ram #(.UPPER_RAM(1'b1)) i_scratchpad_ram_up (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode), .acc_op(acc_op),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .bank_ld(bank_ld), .bank_sel(bank_sel),
    .rd_data(rd_data_o[1]), .rd_err(rd_err_o[1]), .sfr_rd(sfr_rd_o[1]), .sfr_wr(sfr_wr_o[1]),
    .sfr_addr(sfr_addr_o[1]), .sfr_wdata(sfr_wdata_o[1]), .sfr_rdata(sfr_rdata_o[1])
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic [1:0] m, input logic [1:0] o, input logic [7:0] a,
                        input logic [7:0] w, input bit bl, input logic [1:0] bi,
                        input string tag);
    logic [7:0] exp_res [2];
    logic       exp_err [2];
    logic [7:0] new_b   [2];
    logic [7:0] badr    [2];
    bit         ram_w   [2];
    @(negedge clk);
    acc_en = 1'b1; acc_mode = m; acc_op = o; acc_addr = a; acc_wdata = w;
    bank_ld = bl; bank_sel = bi;
    #1;
    for (int k = 0; k < 2; k++) begin
      bit valid, to_sfr, isb, e_rd, e_wr;
      logic [7:0] ba, old, nb;
      logic [2:0] ix;
      valid = 1'b1; to_sfr = 1'b0; isb = 1'b0; ix = a[2:0];
      case (m)
        2'd0: begin ba = a; to_sfr = a[7]; end
        2'd1: begin ba = a; if (a[7] && k == 0) valid = 1'b0; end
        2'd2: ba = {3'b000, bank_m, a[2:0]};
        default: begin
          isb = 1'b1;
          if (a[7]) begin to_sfr = 1'b1; ba = {a[7:3], 3'b000}; end
          else ba = 8'h20 + {4'h0, a[6:3]};
        end
      endcase
      if (!isb && o[1]) valid = 1'b0;
      old = to_sfr ? (ba ^ 8'hA5) : mdl[k][ba];
      nb  = old;
      if (o == 2'd1) begin
        if (isb) nb[ix] = w[0];
        else     nb = w;
      end else if (o == 2'd2) nb[ix] = 1'b1;
      else if (o == 2'd3)     nb[ix] = 1'b0;
      e_rd = valid && to_sfr && (o == 2'd0 || isb);
      e_wr = valid && to_sfr && (o != 2'd0);
      chk(sfr_rd_o[k] == e_rd && sfr_wr_o[k] == e_wr, tag, "sfr strobes",
          {sfr_rd_o[k], sfr_wr_o[k]}, {e_rd, e_wr});
      if (e_rd || e_wr) chk(sfr_addr_o[k] == ba, tag, "sfr_addr", sfr_addr_o[k], ba);
      if (e_wr) chk(sfr_wdata_o[k] == nb, tag, "sfr_wdata", sfr_wdata_o[k], nb);
      exp_err[k] = !valid;
      if (!valid)                           exp_res[k] = 8'h00;
      else if (to_sfr && !isb && o == 2'd1) exp_res[k] = 8'h00;
      else if (isb)                         exp_res[k] = {7'b0, old[ix]};
      else                                  exp_res[k] = old;
      ram_w[k] = valid && !to_sfr && (o != 2'd0);
      new_b[k] = nb;
      badr[k]  = ba;
    end
    @(posedge clk);
    #1;
    acc_en = 1'b0; bank_ld = 1'b0;
    for (int k = 0; k < 2; k++) begin
      chk(rd_data_o[k] == exp_res[k], tag, "rd_data", rd_data_o[k], exp_res[k]);
      chk(rd_err_o[k] == exp_err[k], tag, "rd_err", rd_err_o[k], exp_err[k]);
      if (ram_w[k]) mdl[k][badr[k]] = new_b[k];
    end
    if (bl) bank_m = bi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_mode = '0; acc_op = '0; acc_addr = '0;
    acc_wdata = '0; bank_ld = 1'b0; bank_sel = '0; bank_m = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state at the ports
    for (int k = 0; k < 2; k++) begin
      chk(rd_data_o[k] == 8'h00, "R2", "rd_data reset", rd_data_o[k], 8'h00);
      chk(rd_err_o[k] == 1'b0, "R2", "rd_err reset", rd_err_o[k], 1'b0);
      chk(!sfr_rd_o[k] && !sfr_wr_o[k], "R2", "strobes reset",
          {sfr_rd_o[k], sfr_wr_o[k]}, 2'b00);
    end

    // R4: fill through indirect writes; upper half invalid without upper RAM
    for (int a = 0; a < 256; a++)
      do_acc(2'd1, 2'd1, 8'(a), 8'(a * 37 + 11), 1'b0, 2'd0, "R4");

    // R2: bank starts at 0, so R0..R7 read bytes 00h..07h
    for (int n = 0; n < 8; n++)
      do_acc(2'd2, 2'd0, 8'(n), 8'h00, 1'b0, 2'd0, "R2");

    // R3: direct reads over the full range
    for (int a = 0; a < 256; a++)
      do_acc(2'd0, 2'd0, 8'(a), 8'h00, 1'b0, 2'd0, "R3");

    // R4: indirect reads over the full range
    for (int a = 0; a < 256; a++)
      do_acc(2'd1, 2'd0, 8'(a), 8'h00, 1'b0, 2'd0, "R4");

    // R1: bank load together with the first write of each bank
    for (int b = 3; b >= 0; b--)
      for (int n = 0; n < 8; n++)
        do_acc(2'd2, 2'd1, 8'(n), {b[1:0], 3'b101, n[2:0]}, n == 0, b[1:0], "R1");
    for (int a = 0; a < 32; a++)
      do_acc(2'd0, 2'd0, 8'(a), 8'h00, 1'b0, 2'd0, "R1");

    // R5 / R7 / R8: every RAM bit address with each op
    for (int b = 0; b < 128; b++) begin
      do_acc(2'd3, 2'd2, 8'(b), 8'h00, 1'b0, 2'd0, "R5");
      do_acc(2'd3, 2'd0, 8'(b), 8'h00, 1'b0, 2'd0, "R8");
      do_acc(2'd0, 2'd0, 8'h20 + 8'(b / 8), 8'h00, 1'b0, 2'd0, "R7");
      do_acc(2'd3, 2'd3, 8'(b), 8'h00, 1'b0, 2'd0, "R7");
      do_acc(2'd3, 2'd1, 8'(b), 8'(b % 2), 1'b0, 2'd0, "R7");
    end

    // R6: every special-register bit address with each op
    for (int b = 128; b < 256; b++)
      for (int o = 0; o < 4; o++)
        do_acc(2'd3, 2'(o), 8'(b), 8'(b), 1'b0, 2'd0, "R6");

    // R7: byte write then bit reads of the same byte
    do_acc(2'd0, 2'd1, 8'h20, 8'hFF, 1'b0, 2'd0, "R7");
    for (int b = 0; b < 8; b++) do_acc(2'd3, 2'd0, 8'(b), 8'h00, 1'b0, 2'd0, "R7");
    do_acc(2'd1, 2'd1, 8'h2F, 8'h5A, 1'b0, 2'd0, "R7");
    for (int b = 120; b < 128; b++) do_acc(2'd3, 2'd0, 8'(b), 8'h00, 1'b0, 2'd0, "R7");

    // R9: set/clear outside bit mode are rejected and change nothing
    do_acc(2'd0, 2'd2, 8'h30, 8'h00, 1'b0, 2'd0, "R9");
    do_acc(2'd1, 2'd3, 8'h30, 8'h00, 1'b0, 2'd0, "R9");
    do_acc(2'd2, 2'd2, 8'h03, 8'h00, 1'b0, 2'd0, "R9");
    do_acc(2'd0, 2'd3, 8'h90, 8'h00, 1'b0, 2'd0, "R9");
    do_acc(2'd0, 2'd0, 8'h30, 8'h00, 1'b0, 2'd0, "R9");
    do_acc(2'd1, 2'd0, 8'h1B, 8'h00, 1'b0, 2'd0, "R9");

    // R10: special-register byte writes and reads
    do_acc(2'd0, 2'd1, 8'h99, 8'h3C, 1'b0, 2'd0, "R10");
    do_acc(2'd0, 2'd1, 8'hF0, 8'hC3, 1'b0, 2'd0, "R10");
    do_acc(2'd0, 2'd0, 8'h81, 8'h00, 1'b0, 2'd0, "R10");

    // R8: outputs hold while idle
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(rd_data_o[k] == 8'(8'h81 ^ 8'hA5), "R8", "rd_data hold",
          rd_data_o[k], 8'h81 ^ 8'hA5);

    // R3: upper-RAM copy keeps its indirect bytes after direct traffic above 7Fh
    for (int a = 128; a < 256; a += 17)
      do_acc(2'd1, 2'd0, 8'(a), 8'h00, 1'b0, 2'd0, "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule